// File: doc/BRIEF.md
# Auto-Incrementing Graphics ROM Emulation Port

This block makes writable SRAM look like a set of byte-serial graphics ROM devices on a byte-wide CPU bus. The CPU never presents a memory address directly. It loads a 16-bit pointer through an address port, one byte per write, and then moves bytes through a data port. Every data access uses the pointer and then advances it by one, so a stream of reads or writes walks through memory sequentially.

Only two windows of the 64 KiB pointer space are backed. Pointers in 0x6000-0x7FFF go to SRAM region A, and pointers with bit 15 set go to SRAM region B. The CPU address carries a port-bank number that is decoded from bits 3:2. In extended mode that number becomes the top bits of the SRAM address, so each bank has its own slice: 4 x 8 KiB in region A and 4 x 32 KiB in region B. In basic mode the number is dropped and all banks alias. An enable input, which comes from an external control latch, gates every effect of the block.

The CPU side uses plain strobes with no back-pressure. A strobe is one clock wide and is always accepted. The read result comes back one cycle later as a `rd_valid`/`rd_data` pair that has no ready signal. The consumer must take it in that cycle. The SRAM side expects a synchronous read: data is returned on `a_rdata`/`b_rdata` in the cycle after the matching select.

Top module: `grom_port_emu`

## Requirements
- R1: A read strobe is a data read only when `(cpu_addr & 0xFC03) == 0x9800` and no write strobe is present. Any other read address leaves the pointer and the SRAM selects untouched.
- R2: A write strobe is a port write when `(cpu_addr & 0xFC01) == 0x9C00`. In a port write, cpu_addr bit 1 = 1 means an address write and bit 1 = 0 means a data write. Bits 9:4 are ignored in both decodes.
- R3: Each address write moves the pointer's low byte into its high byte and puts the written byte in the low byte. Two writes therefore load the high byte first, then the low byte.
- R4: Each data read or data write uses the current pointer and then increments it by one. The carry ripples through all 16 bits, so 0x7FFF goes to 0x8000 and 0xFFFF wraps to 0x0000.
- R5: A pointer with bits 15:13 = 011 selects region A (`a_cs`=1). In extended mode, `a_addr = {bank, ptr[12:0]}`, where bank = cpu_addr bits 3:2.
- R6: A pointer with bit 15 = 1 selects region B (`b_cs`=1). In extended mode, `b_addr = {bank, ptr[14:0]}`. During a data write, `mem_we`=1 and `mem_wdata` carries the CPU byte.
- R7: A pointer below 0x6000 selects no region. A data read there returns no valid data, and the pointer still increments.
- R8: While `enable`=0, reads, data writes and address writes have no effect: no select, no write enable, and the pointer is unchanged.
- R9: With `ext_mode`=0, the bank bits of `a_addr`/`b_addr` are 0, so all four banks reach the same bytes.
- R10: `rd_valid` is 1 exactly one cycle after a data read that hit region A or B, and `rd_data` then carries that region's SRAM byte. When `rd_valid`=0, `rd_data` = 0xFF.
- R11: A synchronous reset (`rst`=1) clears the pointer to 0x0000 and clears `rd_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| enable | input | 1 | Card enable from the control latch |
| ext_mode | input | 1 | 1 = banks map to separate SRAM slices, 0 = banks alias |
| cpu_addr | input | 16 | CPU byte address |
| cpu_rd | input | 1 | CPU read strobe, one cycle |
| cpu_wr | input | 1 | CPU write strobe, one cycle |
| cpu_wdata | input | 8 | CPU write data |
| rd_data | output | 8 | Read result, 0xFF when not valid |
| rd_valid | output | 1 | Read result valid, no ready |
| a_cs | output | 1 | Region A SRAM select |
| a_addr | output | 15 | Region A SRAM byte address |
| b_cs | output | 1 | Region B SRAM select |
| b_addr | output | 17 | Region B SRAM byte address |
| mem_we | output | 1 | SRAM write enable, shared by both regions |
| mem_wdata | output | 8 | SRAM write data |
| a_rdata | input | 8 | Region A SRAM read data, one cycle after select |
| b_rdata | input | 8 | Region B SRAM read data, one cycle after select |

## Verification
The bench goes after the pointer edges. At 0x7FFF to 0x8000 the increment crosses from region A into region B, and a counter whose carry stops at a nibble boundary would land in the wrong region. At 0xFFFF the pointer wraps to a miss, and at 0x5FFF to 0x6000 a read must miss yet still advance the pointer, which catches any design that only steps on hits. The bench also loads the pointer through aliased port addresses that have bits 9:4 set, presents near-miss addresses that have bit 1 set on a read or bit 10 clear on a write, and checks in basic mode that a byte written through one bank reads back through another. Finally, a reset applied while the pointer's low byte is non-zero, followed by a single address write, exposes a reset that fails to clear the pointer: that read would hit 0x6000 instead of missing.

// File: rtl/gpe_pkg.sv
package gpe_pkg;
  localparam int CPU_AW   = 16;
  localparam int PTR_W    = 16;
  localparam int DATA_W   = 8;
  localparam int BANK_W   = 2;
  localparam int A_OFF_W  = 13;
  localparam int B_OFF_W  = 15;

  localparam logic [CPU_AW-1:0] RD_MASK  = 16'hFC03;
  localparam logic [CPU_AW-1:0] RD_MATCH = 16'h9800;
  localparam logic [CPU_AW-1:0] WR_MASK  = 16'hFC01;
  localparam logic [CPU_AW-1:0] WR_MATCH = 16'h9C00;
  localparam int PORT_SEL_BIT = 1;
  localparam int BANK_LSB     = 2;

  localparam int A_TAG_W = PTR_W - A_OFF_W;
  localparam int B_TAG_W = PTR_W - B_OFF_W;
  localparam logic [A_TAG_W-1:0] A_TAG = 3'b011;
  localparam logic [B_TAG_W-1:0] B_TAG = 1'b1;

  typedef enum logic [1:0] {
    RGN_NONE = 2'd0,
    RGN_A    = 2'd1,
    RGN_B    = 2'd2
  } region_e;
endpackage

// File: rtl/gpe_bus_decode.sv
module gpe_bus_decode
  import gpe_pkg::*;
#(
  parameter int AW = CPU_AW,
  parameter int BW = BANK_W
) (
  input  logic [AW-1:0] cpu_addr,
  input  logic          cpu_rd,
  input  logic          cpu_wr,
  input  logic          enable,
  output logic          data_rd,
  output logic          data_wr,
  output logic          addr_wr,
  output logic [BW-1:0] bank
);
  logic rd_match;
  logic wr_match;
  logic port_wr;

  always_comb begin
    rd_match = ((cpu_addr & RD_MASK) == RD_MATCH);
    wr_match = ((cpu_addr & WR_MASK) == WR_MATCH);
    // a write strobe takes precedence over a simultaneous read strobe
    data_rd  = enable && cpu_rd && !cpu_wr && rd_match;
    port_wr  = enable && cpu_wr && wr_match;
    addr_wr  = port_wr && cpu_addr[PORT_SEL_BIT];
    data_wr  = port_wr && !cpu_addr[PORT_SEL_BIT];
    bank     = cpu_addr[BANK_LSB +: BW];
  end
endmodule

// File: rtl/gpe_ptr_counter.sv
module gpe_ptr_counter
  import gpe_pkg::*;
#(
  parameter int PW    = PTR_W,
  parameter int DW    = DATA_W,
  parameter int NIB_W = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [DW-1:0] load_byte,
  input  logic          step,
  output logic [PW-1:0] ptr
);
  localparam int NIBBLES = PW / NIB_W;
  localparam logic [NIB_W-1:0] NIB_ONE = {{(NIB_W-1){1'b0}}, 1'b1};

  logic [PW-1:0] shifted;
  assign shifted = {ptr[PW-DW-1:0], load_byte};

  for (genvar i = 0; i < NIBBLES; i++) begin : g_nib
    logic             cin;
    logic [NIB_W-1:0] nib_q;

    if (i == 0) begin : g_lsb
      assign cin = step;
    end else begin : g_upper
      assign cin = step && (&ptr[i*NIB_W-1:0]);
    end

    always_ff @(posedge clk) begin
      if (rst)
        nib_q <= '0;
      else if (load)
        nib_q <= shifted[i*NIB_W +: NIB_W];
      else if (cin)
        nib_q <= nib_q + NIB_ONE;
    end

    assign ptr[i*NIB_W +: NIB_W] = nib_q;
  end
endmodule

// File: rtl/gpe_region_map.sv
module gpe_region_map
  import gpe_pkg::*;
#(
  parameter int PW  = PTR_W,
  parameter int BW  = BANK_W,
  parameter int AOW = A_OFF_W,
  parameter int BOW = B_OFF_W
) (
  input  logic [PW-1:0]      ptr,
  input  logic [BW-1:0]      bank,
  input  logic               ext_mode,
  output region_e            region,
  output logic [BW+AOW-1:0]  a_addr,
  output logic [BW+BOW-1:0]  b_addr
);
  localparam int ATW = PW - AOW;
  localparam int BTW = PW - BOW;

  logic [BW-1:0] bank_eff;

  always_comb begin
    bank_eff = ext_mode ? bank : '0;
    if (ptr[PW-1 -: BTW] == B_TAG)
      region = RGN_B;
    else if (ptr[PW-1 -: ATW] == A_TAG)
      region = RGN_A;
    else
      region = RGN_NONE;
    a_addr = {bank_eff, ptr[AOW-1:0]};
    b_addr = {bank_eff, ptr[BOW-1:0]};
  end
endmodule

// File: rtl/gpe_read_return.sv
module gpe_read_return
  import gpe_pkg::*;
#(
  parameter int DW = DATA_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          issue,
  input  region_e       issue_rgn,
  input  logic [DW-1:0] a_rdata,
  input  logic [DW-1:0] b_rdata,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data
);
  logic valid_q;
  logic from_b_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q  <= 1'b0;
      from_b_q <= 1'b0;
    end else begin
      valid_q  <= issue && (issue_rgn != RGN_NONE);
      from_b_q <= (issue_rgn == RGN_B);
    end
  end

  assign rd_valid = valid_q;
  assign rd_data  = !valid_q ? {DW{1'b1}} : (from_b_q ? b_rdata : a_rdata);
endmodule

// File: rtl/grom_port_emu.sv
module grom_port_emu
  import gpe_pkg::*;
#(
  parameter int AW  = CPU_AW,
  parameter int PW  = PTR_W,
  parameter int DW  = DATA_W,
  parameter int BW  = BANK_W,
  parameter int AOW = A_OFF_W,
  parameter int BOW = B_OFF_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  logic              ext_mode,
  input  logic [AW-1:0]     cpu_addr,
  input  logic              cpu_rd,
  input  logic              cpu_wr,
  input  logic [DW-1:0]     cpu_wdata,
  output logic [DW-1:0]     rd_data,
  output logic              rd_valid,
  output logic              a_cs,
  output logic [BW+AOW-1:0] a_addr,
  output logic              b_cs,
  output logic [BW+BOW-1:0] b_addr,
  output logic              mem_we,
  output logic [DW-1:0]     mem_wdata,
  input  logic [DW-1:0]     a_rdata,
  input  logic [DW-1:0]     b_rdata
);
  logic          data_rd;
  logic          data_wr;
  logic          load;
  logic          step;
  logic [BW-1:0] bank;
  logic [PW-1:0] gaddr_q;
  region_e       region;

  gpe_bus_decode #(.AW(AW), .BW(BW)) u_decode (
    .cpu_addr (cpu_addr),
    .cpu_rd   (cpu_rd),
    .cpu_wr   (cpu_wr),
    .enable   (enable),
    .data_rd  (data_rd),
    .data_wr  (data_wr),
    .addr_wr  (load),
    .bank     (bank)
  );

  assign step = data_rd || data_wr;

  gpe_ptr_counter #(.PW(PW), .DW(DW)) u_ptr (
    .clk       (clk),
    .rst       (rst),
    .load      (load),
    .load_byte (cpu_wdata),
    .step      (step),
    .ptr       (gaddr_q)
  );

  gpe_region_map #(.PW(PW), .BW(BW), .AOW(AOW), .BOW(BOW)) u_map (
    .ptr      (gaddr_q),
    .bank     (bank),
    .ext_mode (ext_mode),
    .region   (region),
    .a_addr   (a_addr),
    .b_addr   (b_addr)
  );

  assign a_cs      = step && (region == RGN_A);
  assign b_cs      = step && (region == RGN_B);
  assign mem_we    = data_wr && (region != RGN_NONE);
  assign mem_wdata = cpu_wdata;

  gpe_read_return #(.DW(DW)) u_ret (
    .clk       (clk),
    .rst       (rst),
    .issue     (data_rd),
    .issue_rgn (region),
    .a_rdata   (a_rdata),
    .b_rdata   (b_rdata),
    .rd_valid  (rd_valid),
    .rd_data   (rd_data)
  );
endmodule

// File: rtl/gpe_checker.sv
module gpe_checker #(
  parameter int PW = 16,
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          enable,
  input logic          cpu_rd,
  input logic          a_cs,
  input logic          b_cs,
  input logic          mem_we,
  input logic          rd_valid,
  input logic [DW-1:0] rd_data,
  input logic [PW-1:0] gaddr,
  input logic          step,
  input logic          load
);
  localparam int HALF = PW / 2;

  a_r8_quiet_when_disabled: assert property (@(posedge clk) disable iff (rst)
    !enable |-> !(a_cs || b_cs || mem_we));

  a_r8_ptr_hold: assert property (@(posedge clk) disable iff (rst)
    !enable |=> $stable(gaddr));

  a_r4_step_increments: assert property (@(posedge clk) disable iff (rst)
    (step && !load) |=> gaddr == PW'($past(gaddr) + 1'b1));

  a_r3_load_shifts: assert property (@(posedge clk) disable iff (rst)
    load |=> gaddr[PW-1:HALF] == $past(gaddr[HALF-1:0]));

  a_r5_single_region: assert property (@(posedge clk) disable iff (rst)
    $onehot0({a_cs, b_cs}));

  a_r10_valid_source: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> $past(cpu_rd && (a_cs || b_cs) && !mem_we));

  a_r10_idle_ff: assert property (@(posedge clk) disable iff (rst)
    !rd_valid |-> rd_data == {DW{1'b1}});

  a_r11_reset_clears: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (gaddr == '0 && !rd_valid));
endmodule

bind grom_port_emu gpe_checker #(.PW(PW), .DW(DW)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .enable   (enable),
  .cpu_rd   (cpu_rd),
  .a_cs     (a_cs),
  .b_cs     (b_cs),
  .mem_we   (mem_we),
  .rd_valid (rd_valid),
  .rd_data  (rd_data),
  .gaddr    (gaddr_q),
  .step     (step),
  .load     (load)
);

// File: tb/grom_port_emu_tb.sv
module grom_port_emu_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        enable = 1'b1;
  logic        ext_mode = 1'b1;
  logic [15:0] cpu_addr = '0;
  logic        cpu_rd = 1'b0;
  logic        cpu_wr = 1'b0;
  logic [7:0]  cpu_wdata = '0;
  logic [7:0]  rd_data;
  logic        rd_valid;
  logic        a_cs;
  logic [14:0] a_addr;
  logic        b_cs;
  logic [16:0] b_addr;
  logic        mem_we;
  logic [7:0]  mem_wdata;
  logic [7:0]  a_rdata;
  logic [7:0]  b_rdata;

  logic [7:0] mem_a [0:32767];
  logic [7:0] mem_b [0:131071];

  int total = 0;
  int fails = 0;

  logic [7:0] exp_q [$];
  string      tag_q [$];

  logic        o_acs, o_bcs, o_we;
  logic [14:0] o_aaddr;
  logic [16:0] o_baddr;

  always #(CLK_PERIOD/2) clk = ~clk;

  grom_port_emu u_dut (
    .clk(clk), .rst(rst), .enable(enable), .ext_mode(ext_mode),
    .cpu_addr(cpu_addr), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata),
    .rd_data(rd_data), .rd_valid(rd_valid),
    .a_cs(a_cs), .a_addr(a_addr), .b_cs(b_cs), .b_addr(b_addr),
    .mem_we(mem_we), .mem_wdata(mem_wdata),
    .a_rdata(a_rdata), .b_rdata(b_rdata)
  );

  function automatic logic [7:0] pat_a(input int i);
    return 8'(i * 13 + 5) ^ 8'(i >> 8);
  endfunction
  function automatic logic [7:0] pat_b(input int i);
    return 8'(i * 29 + 11) ^ 8'(i >> 7);
  endfunction

  // SRAM models: synchronous read, write on select with write enable
  always @(posedge clk) begin
    if (a_cs) begin
      if (mem_we) mem_a[a_addr] <= mem_wdata;
      a_rdata <= mem_a[a_addr];
    end
    if (b_cs) begin
      if (mem_we) mem_b[b_addr] <= mem_wdata;
      b_rdata <= mem_b[b_addr];
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // monitor: pops scoreboard entries whenever a read result is presented
  always @(negedge clk) begin
    if (!rst && rd_valid) begin
      if (exp_q.size() == 0) begin
        check("R10 unexpected rd_valid", 32'(rd_valid), 32'd0);
      end else begin
        automatic logic [7:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        check(t, 32'(rd_data), 32'(e));
      end
    end
  end

  // one bus operation: drive at negedge, capture SRAM-side outputs, release next negedge
  task automatic bus_op(input logic rd, input logic wr, input logic [15:0] a,
                        input logic [7:0] d, input logic push, input logic [7:0] exp,
                        input string tag);
    @(negedge clk);
    cpu_addr = a; cpu_rd = rd; cpu_wr = wr; cpu_wdata = d;
    if (push) begin
      exp_q.push_back(exp);
      tag_q.push_back(tag);
    end
    #1;
    o_acs = a_cs; o_bcs = b_cs; o_we = mem_we; o_aaddr = a_addr; o_baddr = b_addr;
    @(negedge clk);
    cpu_rd = 1'b0; cpu_wr = 1'b0;
  endtask

  task automatic set_ptr(input logic [15:0] port, input logic [15:0] p);
    bus_op(1'b0, 1'b1, port, p[15:8], 1'b0, 8'h00, "");
    bus_op(1'b0, 1'b1, port, p[7:0], 1'b0, 8'h00, "");
  endtask

  task automatic read_hit(input logic [15:0] a, input logic [7:0] exp, input string tag);
    bus_op(1'b1, 1'b0, a, 8'h00, 1'b1, exp, tag);
  endtask

  task automatic read_miss(input string tag);
    bus_op(1'b1, 1'b0, 16'h9800, 8'h00, 1'b0, 8'h00, tag);
    check({tag, " no select"}, 32'({o_acs, o_bcs}), 32'd0);
    check({tag, " rd_valid low"}, 32'(rd_valid), 32'd0);
    check({tag, " rd_data FF"}, 32'(rd_data), 32'hFF);
  endtask

  initial begin
    for (int i = 0; i < 32768; i++) mem_a[i] = pat_a(i);
    for (int i = 0; i < 131072; i++) mem_b[i] = pat_b(i);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11 reset state
    check("R11 rd_valid after reset", 32'(rd_valid), 32'd0);
    check("R10 rd_data FF after reset", 32'(rd_data), 32'hFF);
    read_miss("R11 pointer 0 after reset");

    // R3 R5 R1: two-byte load then bank-0 read in region A
    set_ptr(16'h9C02, 16'h6010);
    read_hit(16'h9800, pat_a(16'h0010), "R5 region A bank0 data");
    check("R3/R5 a_addr after load", 32'(o_aaddr), 32'h0010);
    check("R1 a_cs on data read", 32'({o_acs, o_bcs}), 32'b10);
    // R4 increment, bank 1
    read_hit(16'h9804, pat_a(16'h2011), "R4 bank1 data");
    check("R4/R5 a_addr bank1", 32'(o_aaddr), 32'h2011);
    // R2 bits 9:4 ignored, bank 2
    read_hit(16'h9BF8, pat_a(16'h4012), "R2 aliased read data");
    check("R2 a_addr aliased bank2", 32'(o_aaddr), 32'h4012);
    // R1 near-miss read address (bit 1 set) does nothing
    bus_op(1'b1, 1'b0, 16'h9802, 8'h00, 1'b0, 8'h00, "");
    check("R1 non-port read no select", 32'({o_acs, o_bcs}), 32'd0);
    read_hit(16'h9800, pat_a(16'h0013), "R1 pointer not advanced data");
    check("R1 pointer not advanced", 32'(o_aaddr), 32'h0013);
    // R2 near-miss write address (bit 10 clear)
    bus_op(1'b0, 1'b1, 16'h9800, 8'h55, 1'b0, 8'h00, "");
    check("R2 non-port write ignored", 32'({o_acs, o_bcs, o_we}), 32'd0);

    // R6 region B write through bank 3 with aliased address-port loads
    bus_op(1'b0, 1'b1, 16'h9FF2, 8'h81, 1'b0, 8'h00, "");
    bus_op(1'b0, 1'b1, 16'h9C0E, 8'h23, 1'b0, 8'h00, "");
    bus_op(1'b0, 1'b1, 16'h9C0C, 8'hA5, 1'b0, 8'h00, "");
    check("R6 b_cs and mem_we on data write", 32'({o_bcs, o_we}), 32'b11);
    check("R6 b_addr bank3", 32'(o_baddr), 32'h18123);
    set_ptr(16'h9C02, 16'h8123);
    read_hit(16'h980C, 8'hA5, "R6 write readback");

    // R4 carry from region A into region B
    set_ptr(16'h9C02, 16'h7FFF);
    read_hit(16'h9800, pat_a(16'h1FFF), "R4 last A byte");
    read_hit(16'h9800, pat_b(0), "R4 carry into B");
    check("R4 carry crosses to b_addr 0", 32'({o_bcs, o_baddr}), {14'd0, 1'b1, 17'd0});
    // R4 wrap at top
    set_ptr(16'h9C02, 16'hFFFF);
    read_hit(16'h9800, pat_b(16'h7FFF), "R4 last B byte");
    read_miss("R4 wrap to 0000");
    // R7 miss below 0x6000 still increments
    set_ptr(16'h9C02, 16'h5FFF);
    read_miss("R7 pointer 5FFF");
    read_hit(16'h9800, pat_a(0), "R7 increment after miss");
    check("R7 a_addr after miss", 32'(o_aaddr), 32'h0000);

    // R8 disabled: nothing takes effect
    enable = 1'b0;
    bus_op(1'b1, 1'b0, 16'h9800, 8'h00, 1'b0, 8'h00, "");
    check("R8 read disabled no select", 32'({o_acs, o_bcs}), 32'd0);
    set_ptr(16'h9C02, 16'h8000);
    bus_op(1'b0, 1'b1, 16'h9C00, 8'h77, 1'b0, 8'h00, "");
    check("R8 write disabled no we", 32'({o_acs, o_bcs, o_we}), 32'd0);
    enable = 1'b1;
    read_hit(16'h9800, pat_a(1), "R8 pointer kept data");
    check("R8 pointer kept", 32'(o_aaddr), 32'h0001);

    // R9 basic mode: bank bits dropped
    ext_mode = 1'b0;
    set_ptr(16'h9C02, 16'h8005);
    read_hit(16'h980C, pat_b(5), "R9 basic B data");
    check("R9 basic b_addr", 32'(o_baddr), 32'h00005);
    set_ptr(16'h9C02, 16'h6100);
    bus_op(1'b0, 1'b1, 16'h9C08, 8'h3C, 1'b0, 8'h00, "");
    check("R9 basic write a_addr", 32'(o_aaddr), 32'h0100);
    set_ptr(16'h9C02, 16'h6100);
    read_hit(16'h9804, 8'h3C, "R9 alias readback");
    ext_mode = 1'b1;

    // R11 reset clears pointer while low byte is non-zero
    set_ptr(16'h9C02, 16'h8260);
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk); rst = 1'b0;
    bus_op(1'b0, 1'b1, 16'h9C02, 8'h00, 1'b0, 8'h00, "");
    read_miss("R11 reset cleared pointer");

    repeat (3) @(negedge clk);
    check("R10 scoreboard drained", 32'(exp_q.size()), 32'd0);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule